// File: doc/BRIEF.md
# Majority-Logic Decoder With Early Detection

This block decodes one 15-bit word of a cyclic (15,7) code that corrects up to two bit errors, as read from a protected memory. The word is captured into a circular shift register. Every cycle, four parity check sums that are orthogonal on the top bit are formed from the register. The top bit is corrected by majority vote, and the register rotates by one place.

Error detection takes only the first three cycles. If no check sum has been nonzero in those cycles, the word is known to be clean. The block then stops and releases the data on the fourth cycle after the load. If any check sum has been nonzero, it keeps rotating and correcting until all fifteen positions have been visited. It then releases the corrected data with an error flag.

Data bits are stored systematically in the top seven bits. The user drives a one-cycle load with the word, waits for the valid pulse, and reads the data and the flag. These stay unchanged until the next result.

Top module: `ml_decoder_early`

## Requirements
- R1: After reset, busy, out_valid and err_det are 0 and data_out is 0.
- R2: A load seen while idle captures code_in, and busy is 1 from the next cycle.
- R3: When all check sums are zero on three successive evaluations, busy lasts exactly 3 cycles. out_valid is 1 in the fourth cycle after the load edge, with err_det 0 and data_out equal to code_in[14:8].
- R4: When any check sum is nonzero during the first three evaluations, busy lasts exactly 15 cycles. out_valid follows in the next cycle, with err_det 1.
- R5: Codewords are systematic multiples of the generator x^8+x^7+x^6+x^4+1, with data in bits 14..8. The check sums on bit 14 are the XORs over {14,0,2,6}, {14,13,1,5}, {14,11,12,3} and {14,7,8,10}. Bit 14 is flipped when at least three of them are 1. Any single bit error, in any of the 15 positions, yields the original data.
- R6: Any two bit errors yield the original data. Two errors off the decoded bit never reach the flip threshold.
- R7: A load while busy is ignored. The result and its timing are those of the word already in progress.
- R8: out_valid is a single-cycle pulse. data_out and err_det change only in the cycle in which out_valid is 1, and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| load | input | 1 | start strobe for code_in |
| code_in | input | 15 | received codeword, data in bits 14..8 |
| busy | output | 1 | decode in progress |
| out_valid | output | 1 | one-cycle result strobe |
| data_out | output | 7 | corrected data bits |
| err_det | output | 1 | a nonzero check sum was seen for this word |

## Verification
The decoder is tried with four kinds of word:
- Clean codewords, including all zeros and all ones. These separate the early exit from the full pass by latency alone.
- Single errors at the decoded bit and at the far end. These show that every single error position trips detection and gets corrected.
- Double errors, including pairs that miss the first decoded bit's check sums and an adjacent pair. These tell apart correct majority thresholds from a premature flip.
- Seeded random data with zero to two random error positions. These are compared against a bench encoder, together with loads issued mid-decode that must leave the result untouched.

// File: rtl/ml_decoder_early.sv
module ml_decoder_early (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [14:0] code_in,
  output logic        busy,
  output logic        out_valid,
  output logic [6:0]  data_out,
  output logic        err_det
);
  localparam int N = 15;
  localparam int DET = 3;
  localparam logic [3:0] DET_END = 4'(DET - 1);
  localparam logic [3:0] LAST = 4'(N - 1);

  logic [N-1:0] sh;
  logic [3:0]   cnt;
  logic         run, err_seen;

  wire [3:0] chk = {^{sh[14], sh[0],  sh[2],  sh[6]},
                    ^{sh[14], sh[13], sh[1],  sh[5]},
                    ^{sh[14], sh[11], sh[12], sh[3]},
                    ^{sh[14], sh[7],  sh[8],  sh[10]}};
  wire any  = |chk;
  wire flip = (chk[0] & chk[1] & (chk[2] | chk[3])) |
              (chk[2] & chk[3] & (chk[0] | chk[1]));
  wire [N-1:0] nxt = {sh[N-2:0], sh[N-1] ^ flip};
  wire early = (cnt == DET_END) && !err_seen && !any;
  wire last  = (cnt == LAST);

  assign busy = run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0; cnt <= '0; run <= 1'b0; err_seen <= 1'b0;
      out_valid <= 1'b0; data_out <= '0; err_det <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (!run) begin
        if (load) begin
          sh <= code_in; cnt <= '0; run <= 1'b1; err_seen <= 1'b0;
        end
      end else begin
        sh <= nxt;
        cnt <= cnt + 4'd1;
        err_seen <= err_seen | any;
        if (early) begin
          run <= 1'b0; out_valid <= 1'b1; err_det <= 1'b0;
          data_out <= {nxt[2:0], nxt[14:11]};
        end else if (last) begin
          run <= 1'b0; out_valid <= 1'b1; err_det <= err_seen | any;
          data_out <= nxt[14:8];
        end
      end
    end
  end

  logic [4:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n) run_len <= '0;
    else if (load && !run) run_len <= '0;
    else if (run) run_len <= run_len + 5'd1;
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load && !busy |=> busy);
  p_latency_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (run_len == 5'd3 && !err_det) || (run_len == 5'd15 && err_det));
  p_end_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> out_valid);
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(data_out) && $stable(err_det));
endmodule

// File: tb/ml_decoder_early_test.sv
module ml_decoder_early_test;
  logic clk = 0, rst_n = 0, load = 0;
  logic [14:0] code_in = '0;
  logic busy, out_valid, err_det;
  logic [6:0] data_out;
  int n_chk = 0, n_fail = 0, cyc = 0;

  ml_decoder_early uut (.clk(clk), .rst_n(rst_n), .load(load), .code_in(code_in),
    .busy(busy), .out_valid(out_valid), .data_out(data_out), .err_det(err_det));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [14:0] encode(input logic [6:0] d);
    logic [14:0] r = {d, 8'b0};
    for (int i = 14; i >= 8; i--)
      if (r[i]) r = r ^ (15'(9'b111010001) << (i - 8));
    return {d, r[7:0]};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_word(input logic [6:0] d, input logic [14:0] emask,
                          input bit mid_load, input string tag);
    int k = 0;
    bit dirty = (emask != 0);
    logic [6:0] held;
    @(negedge clk); load = 1; code_in = encode(d) ^ emask;
    @(negedge clk); load = 0;
    check({tag, " R2 busy"}, busy, 1);
    if (mid_load) begin load = 1; code_in = ~code_in; end
    while (!out_valid && k < 20) begin
      @(negedge clk); k++; load = 0;
    end
    check({tag, dirty ? " R4 latency" : " R3 latency"}, k, dirty ? 15 : 3);
    check({tag, dirty ? " R5/R6 data" : " R3 data"}, data_out, d);
    check({tag, " R3/R4 err_det"}, err_det, dirty);
    if (mid_load) check({tag, " R7 ignored load"}, data_out, d);
    held = data_out;
    @(negedge clk);
    check({tag, " R8 pulse"}, out_valid, 0);
    check({tag, " R8 hold"}, data_out, held);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 out_valid", out_valid, 0);
    check("R1 err_det", err_det, 0);
    check("R1 data_out", data_out, 0);
    rst_n = 1;
    run_word(7'h00, 15'h0, 0, "zero");
    run_word(7'h7f, 15'h0, 0, "ones");
    run_word(7'h2a, 15'h4000, 0, "err14");
    run_word(7'h55, 15'h0001, 0, "err0");
    run_word(7'h33, 15'h0210, 0, "err4_9");
    run_word(7'h19, 15'h6000, 0, "err13_14");
    run_word(7'h4c, 15'h0000, 1, "r7_clean");
    run_word(7'h61, 15'h0100, 1, "r7_dirty");
    for (int i = 0; i < 60; i++) begin
      logic [6:0] d = 7'($urandom);
      int ne = $urandom_range(0, 2);
      logic [14:0] m = '0;
      int p1 = $urandom_range(0, 14);
      int p2 = (p1 + $urandom_range(1, 14)) % 15;
      if (ne >= 1) m[p1] = 1'b1;
      if (ne == 2) m[p2] = 1'b1;
      run_word(d, m, (i % 7) == 3, "rand");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule